// File: doc/BRIEF.md
# MSI PQ-State Event Controller

This block takes one interrupt trigger at a time for a numbered message-signalled source and turns it into either a single byte write to that source's table entry or an interrupt delivered to a presentation interface. On acceptance it forms the entry address from a table base, the source number and a configurable entry stride. It drops the trigger at once if the table is disabled or the source lies beyond the table length. Otherwise it fetches the 64-bit entry through a read request/response port.

The entry is stored big-endian. The block byte-swaps it and extracts a server field, a generation field, a priority and the two state bits P (pending) and Q (queued). It then applies the state rules. With both bits clear and a real priority, it marks P (with the generation) and then delivers. With both bits clear and the masked priority, or with only P set, it marks Q. With Q set, it drops the trigger. A forced trigger, used for retries, acts as if both bits were clear.

All streaming ports use valid/ready. A valid, once raised, stays high with its payload unchanged until the matching ready is seen, and the block adds no buffering. The trigger port is ready only while the block is idle, so back-pressure on any downstream port holds off the next trigger. A read or write error response aborts the event.

Top module: `msi_pq_ctrl`

## Requirements
- R1: The entry address on `rd_req_addr` is `cfg_tbl_base + trig_src*16`, or `cfg_tbl_base + trig_src*128` when `cfg_big_entry` is 1.
- R2: A trigger accepted while `cfg_tbl_en` is 0 is consumed with no read request, no write and no delivery.
- R3: A trigger whose source is greater than or equal to `cfg_tbl_len` is consumed with no memory access. Source `cfg_tbl_len-1` is still fetched.
- R4: If the fetched entry has P=0, Q=0 and priority 0xFF (masked), the block writes byte 0x01 to entry address + 5 and delivers nothing.
- R5: If the entry has P=0, Q=0 and any other priority, the block writes byte `0x01 | (gen<<1)` to entry address + 4. After that write completes without error, it delivers with `irq_server` = server field >> 2, `irq_num` = `cfg_irq_base + trig_src` and `irq_prio` = the priority.
- R6: If the entry has P=1 and Q=0, the block writes byte 0x01 to entry address + 5 and delivers nothing.
- R7: If the entry has Q=1, the trigger is dropped: no write and no delivery, and the block returns to idle.
- R8: When `trig_force` is 1, the entry's P and Q bits are ignored and handled as P=0, Q=0.
- R9: Response byte lane k (`rd_rsp_data[8k+7:8k]`) is the byte at entry address + k, and the entry is big-endian. Bytes 0..1 hold the 16-bit server (byte 0 most significant). Byte 4 holds P in bit 0 and gen in bits 2:1. Byte 5 holds Q in bit 0. Byte 7 holds the priority.
- R10: `trig_ready` is 1 only when idle, and at most one of `rd_req_valid`, `wr_valid` and `irq_valid` is 1 at a time. Each raised valid holds with a stable payload until its ready is seen.
- R11: A read or write response with its error bit set raises `err_abort` during that response cycle. The event then ends with no further write or delivery, and the block is idle in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_tbl_base | input | ADDR_W | Vector table base address |
| cfg_tbl_en | input | 1 | Table enable |
| cfg_tbl_len | input | SRC_W+1 | Number of table entries |
| cfg_big_entry | input | 1 | 1 selects a 128-byte entry stride, 0 a 16-byte stride |
| cfg_irq_base | input | IRQ_W | Offset added to the source number for delivery |
| trig_valid | input | 1 | Trigger request |
| trig_ready | output | 1 | Trigger accepted (block idle) |
| trig_src | input | SRC_W | Source number |
| trig_force | input | 1 | Retry: ignore the stored P/Q |
| rd_req_valid | output | 1 | Entry read request |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | ADDR_W | Entry address |
| rd_rsp_valid | input | 1 | Read response |
| rd_rsp_data | input | 64 | Entry bytes, lane k = address + k |
| rd_rsp_err | input | 1 | Read error |
| wr_valid | output | 1 | Byte write request |
| wr_ready | input | 1 | Write request accepted |
| wr_addr | output | ADDR_W | Byte address |
| wr_data | output | 8 | Byte value |
| wr_rsp_valid | input | 1 | Write completion |
| wr_rsp_err | input | 1 | Write error |
| irq_valid | output | 1 | Delivery request |
| irq_ready | input | 1 | Delivery accepted |
| irq_server | output | 14 | Target server |
| irq_num | output | IRQ_W | Interrupt number |
| irq_prio | output | 8 | Priority |
| err_abort | output | 1 | Event aborted on an error response |

## Verification
The bench goes after the state-rule corners. A design that ignored the masked code would deliver a masked source. One that confused the P and Q bytes would write to offset 4 instead of 5, and one that read the entry without the byte swap would pick up server and priority from the wrong lanes. It also checks forced sends on entries with both bits set, which a design that honoured the stored state would silently drop. It probes the length bound at len-1 and len, where an off-by-one either fetches past the table or loses the last entry. Error responses on both the read and the write are applied; a design that carried on would write, or deliver after a failed P update. Held ready signals show whether the payload stays stable and whether a second trigger is wrongly taken while busy.

// File: rtl/msi_pq_pkg.sv
package msi_pq_pkg;

  localparam int unsigned ENTRY_BYTES  = 8;
  localparam int unsigned SRV_RAW_W    = 16;
  localparam int unsigned LINK_W       = 2;
  localparam int unsigned SRV_W        = SRV_RAW_W - LINK_W;
  localparam int unsigned P_BYTE_OFS   = 4;
  localparam int unsigned Q_BYTE_OFS   = 5;
  localparam int unsigned SMALL_SHIFT  = 4;
  localparam int unsigned LARGE_SHIFT  = 7;
  localparam logic [7:0]  PRIO_MASKED  = 8'hFF;

  typedef enum logic [1:0] {
    ACT_DROP  = 2'd0,
    ACT_SET_Q = 2'd1,
    ACT_SEND  = 2'd2
  } act_e;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RD_REQ  = 3'd1,
    ST_RD_WAIT = 3'd2,
    ST_WR_REQ  = 3'd3,
    ST_WR_WAIT = 3'd4,
    ST_IRQ     = 3'd5
  } st_e;

  typedef struct packed {
    logic [SRV_RAW_W-1:0] server;
    logic [1:0]           gen;
    logic                 p;
    logic                 q;
    logic [7:0]           prio;
  } ive_t;

endpackage

// File: rtl/msi_pq_addr.sv
module msi_pq_addr
  import msi_pq_pkg::*;
#(
  parameter int unsigned SRC_W  = 11,
  parameter int unsigned ADDR_W = 40
) (
  input  logic [SRC_W-1:0]  src,
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic              tbl_en,
  input  logic [SRC_W:0]    tbl_len,
  input  logic              big_entry,
  output logic [ADDR_W-1:0] entry_addr,
  output logic              gate_ok
);

  logic [ADDR_W-1:0] src_wide;
  logic [ADDR_W-1:0] ofs;

  assign src_wide = ADDR_W'(src);

  always_comb begin
    if (big_entry) ofs = src_wide << LARGE_SHIFT;
    else           ofs = src_wide << SMALL_SHIFT;
  end

  assign entry_addr = tbl_base + ofs;
  assign gate_ok    = tbl_en && ({1'b0, src} < tbl_len);

endmodule

// File: rtl/msi_pq_decode.sv
module msi_pq_decode
  import msi_pq_pkg::*;
(
  input  logic [63:0] bus_data,
  input  logic        force_send,
  output ive_t        ive,
  output act_e        act
);

  logic [63:0] be_word;

  for (genvar k = 0; k < ENTRY_BYTES; k++) begin : g_swap
    assign be_word[63-8*k -: 8] = bus_data[8*k +: 8];
  end

  assign ive.server = be_word[63:48];
  assign ive.gen    = be_word[26:25];
  assign ive.p      = be_word[24];
  assign ive.q      = be_word[16];
  assign ive.prio   = be_word[7:0];

  logic [1:0] pq;
  assign pq = force_send ? 2'b00 : {ive.p, ive.q};

  always_comb begin
    unique case (pq)
      2'b00:   act = (ive.prio == PRIO_MASKED) ? ACT_SET_Q : ACT_SEND;
      2'b10:   act = ACT_SET_Q;
      default: act = ACT_DROP;
    endcase
  end

endmodule

// File: rtl/msi_pq_seq.sv
module msi_pq_seq
  import msi_pq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic trig_valid,
  input  logic gate_ok,
  output logic trig_ready,
  output logic accept,
  output logic rd_req_valid,
  input  logic rd_req_ready,
  input  logic rd_rsp_valid,
  input  logic rd_rsp_err,
  output logic rsp_take,
  input  act_e act_now,
  input  act_e act_held,
  output logic wr_valid,
  input  logic wr_ready,
  input  logic wr_rsp_valid,
  input  logic wr_rsp_err,
  output logic irq_valid,
  input  logic irq_ready,
  output logic err_abort
);

  st_e state, state_nx;

  assign trig_ready   = (state == ST_IDLE);
  assign accept       = trig_ready && trig_valid && gate_ok;
  assign rd_req_valid = (state == ST_RD_REQ);
  assign wr_valid     = (state == ST_WR_REQ);
  assign irq_valid    = (state == ST_IRQ);
  assign rsp_take     = (state == ST_RD_WAIT) && rd_rsp_valid && !rd_rsp_err;
  assign err_abort    = ((state == ST_RD_WAIT) && rd_rsp_valid && rd_rsp_err) ||
                        ((state == ST_WR_WAIT) && wr_rsp_valid && wr_rsp_err);

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:    if (accept) state_nx = ST_RD_REQ;
      ST_RD_REQ:  if (rd_req_ready) state_nx = ST_RD_WAIT;
      ST_RD_WAIT: if (rd_rsp_valid) begin
                    if (rd_rsp_err || act_now == ACT_DROP) state_nx = ST_IDLE;
                    else                                   state_nx = ST_WR_REQ;
                  end
      ST_WR_REQ:  if (wr_ready) state_nx = ST_WR_WAIT;
      ST_WR_WAIT: if (wr_rsp_valid) begin
                    if (!wr_rsp_err && act_held == ACT_SEND) state_nx = ST_IRQ;
                    else                                     state_nx = ST_IDLE;
                  end
      ST_IRQ:     if (irq_ready) state_nx = ST_IDLE;
      default:    state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

endmodule

// File: rtl/msi_pq_ctrl.sv
module msi_pq_ctrl
  import msi_pq_pkg::*;
#(
  parameter int unsigned SRC_W  = 11,
  parameter int unsigned ADDR_W = 40,
  parameter int unsigned IRQ_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_tbl_base,
  input  logic              cfg_tbl_en,
  input  logic [SRC_W:0]    cfg_tbl_len,
  input  logic              cfg_big_entry,
  input  logic [IRQ_W-1:0]  cfg_irq_base,
  input  logic              trig_valid,
  output logic              trig_ready,
  input  logic [SRC_W-1:0]  trig_src,
  input  logic              trig_force,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic [63:0]       rd_rsp_data,
  input  logic              rd_rsp_err,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  input  logic              wr_rsp_valid,
  input  logic              wr_rsp_err,
  output logic              irq_valid,
  input  logic              irq_ready,
  output logic [13:0]       irq_server,
  output logic [IRQ_W-1:0]  irq_num,
  output logic [7:0]        irq_prio,
  output logic              err_abort
);

  logic [ADDR_W-1:0] entry_addr;
  logic              gate_ok;
  logic              accept;
  logic              rsp_take;
  ive_t              ive_now;
  act_e              act_now;

  logic [ADDR_W-1:0] entry_addr_q;
  logic              force_q;
  logic [IRQ_W-1:0]  irq_num_q;
  logic [SRV_W-1:0]  server_q;
  logic [1:0]        gen_q;
  logic [7:0]        prio_q;
  act_e              act_q;

  msi_pq_addr #(.SRC_W(SRC_W), .ADDR_W(ADDR_W)) i_addr (
    .src        (trig_src),
    .tbl_base   (cfg_tbl_base),
    .tbl_en     (cfg_tbl_en),
    .tbl_len    (cfg_tbl_len),
    .big_entry  (cfg_big_entry),
    .entry_addr (entry_addr),
    .gate_ok    (gate_ok)
  );

  msi_pq_decode i_decode (
    .bus_data   (rd_rsp_data),
    .force_send (force_q),
    .ive        (ive_now),
    .act        (act_now)
  );

  msi_pq_seq i_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .trig_valid   (trig_valid),
    .gate_ok      (gate_ok),
    .trig_ready   (trig_ready),
    .accept       (accept),
    .rd_req_valid (rd_req_valid),
    .rd_req_ready (rd_req_ready),
    .rd_rsp_valid (rd_rsp_valid),
    .rd_rsp_err   (rd_rsp_err),
    .rsp_take     (rsp_take),
    .act_now      (act_now),
    .act_held     (act_q),
    .wr_valid     (wr_valid),
    .wr_ready     (wr_ready),
    .wr_rsp_valid (wr_rsp_valid),
    .wr_rsp_err   (wr_rsp_err),
    .irq_valid    (irq_valid),
    .irq_ready    (irq_ready),
    .err_abort    (err_abort)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      entry_addr_q <= '0;
      force_q      <= 1'b0;
      irq_num_q    <= '0;
    end else if (accept) begin
      entry_addr_q <= entry_addr;
      force_q      <= trig_force;
      irq_num_q    <= cfg_irq_base + IRQ_W'(trig_src);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      server_q <= '0;
      gen_q    <= '0;
      prio_q   <= '0;
      act_q    <= ACT_DROP;
    end else if (rsp_take) begin
      server_q <= ive_now.server[SRV_RAW_W-1:LINK_W];
      gen_q    <= ive_now.gen;
      prio_q   <= ive_now.prio;
      act_q    <= act_now;
    end
  end

  assign rd_req_addr = entry_addr_q;
  assign wr_addr     = entry_addr_q + ((act_q == ACT_SEND) ? ADDR_W'(P_BYTE_OFS)
                                                           : ADDR_W'(Q_BYTE_OFS));
  assign wr_data     = (act_q == ACT_SEND) ? {5'd0, gen_q, 1'b1} : 8'h01;
  assign irq_server  = server_q;
  assign irq_num     = irq_num_q;
  assign irq_prio    = prio_q;

endmodule

// File: rtl/msi_pq_chk.sv
module msi_pq_chk #(
  parameter int unsigned SRC_W  = 11,
  parameter int unsigned ADDR_W = 40,
  parameter int unsigned IRQ_W  = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_tbl_en,
  input logic [SRC_W:0]    cfg_tbl_len,
  input logic              trig_valid,
  input logic              trig_ready,
  input logic [SRC_W-1:0]  trig_src,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [ADDR_W-1:0] rd_req_addr,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic              irq_valid,
  input logic              irq_ready,
  input logic [13:0]       irq_server,
  input logic [IRQ_W-1:0]  irq_num,
  input logic [7:0]        irq_prio,
  input logic              err_abort
);

  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

  assert_wr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  assert_irq_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && !irq_ready |=> irq_valid && $stable(irq_server) &&
                                $stable(irq_num) && $stable(irq_prio));

  assert_one_port_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_req_valid, wr_valid, irq_valid}) &&
    (!(rd_req_valid || wr_valid || irq_valid) || !trig_ready));

  assert_disabled_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid && trig_ready && !cfg_tbl_en |=> !rd_req_valid && trig_ready);

  assert_bound_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid && trig_ready && ({1'b0, trig_src} >= cfg_tbl_len) |=> !rd_req_valid);

  assert_err_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err_abort |=> trig_ready && !wr_valid && !irq_valid);

endmodule

bind msi_pq_ctrl msi_pq_chk #(.SRC_W(SRC_W), .ADDR_W(ADDR_W), .IRQ_W(IRQ_W)) i_chk (.*);

// File: tb/test_msi_pq_ctrl.sv
module test_msi_pq_ctrl;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned SRC_W  = 11;
  localparam int unsigned ADDR_W = 40;
  localparam int unsigned IRQ_W  = 20;
  localparam logic [ADDR_W-1:0] BASE = 40'h00_1000_0000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] cfg_tbl_base = BASE;
  logic              cfg_tbl_en = 1'b1;
  logic [SRC_W:0]    cfg_tbl_len = 12'd64;
  logic              cfg_big_entry = 1'b0;
  logic [IRQ_W-1:0]  cfg_irq_base = 20'h00100;
  logic              trig_valid = 1'b0;
  logic              trig_ready;
  logic [SRC_W-1:0]  trig_src = '0;
  logic              trig_force = 1'b0;
  logic              rd_req_valid;
  logic              rd_req_ready = 1'b0;
  logic [ADDR_W-1:0] rd_req_addr;
  logic              rd_rsp_valid = 1'b0;
  logic [63:0]       rd_rsp_data = '0;
  logic              rd_rsp_err = 1'b0;
  logic              wr_valid;
  logic              wr_ready = 1'b0;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        wr_data;
  logic              wr_rsp_valid = 1'b0;
  logic              wr_rsp_err = 1'b0;
  logic              irq_valid;
  logic              irq_ready = 1'b0;
  logic [13:0]       irq_server;
  logic [IRQ_W-1:0]  irq_num;
  logic [7:0]        irq_prio;
  logic              err_abort;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msi_pq_ctrl #(.SRC_W(SRC_W), .ADDR_W(ADDR_W), .IRQ_W(IRQ_W)) i_msi_pq_ctrl (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Entry bytes as seen on the bus: lane k = byte at entry address + k (R9).
  function automatic logic [63:0] mk_entry(input logic [15:0] srv, input logic [1:0] gen,
                                           input bit p, input bit q, input logic [7:0] prio);
    logic [7:0] b [8];
    logic [63:0] r;
    for (int k = 0; k < 8; k++) b[k] = 8'h00;
    b[0] = srv[15:8];
    b[1] = srv[7:0];
    b[2] = 8'hA5;
    b[3] = 8'h5A;
    b[4] = {5'd0, gen, p};
    b[5] = {7'd0, q};
    b[6] = 8'hC3;
    b[7] = prio;
    for (int k = 0; k < 8; k++) r[8*k +: 8] = b[k];
    return r;
  endfunction

  task automatic trig(input logic [SRC_W-1:0] s, input bit f);
    trig_valid = 1'b1;
    trig_src   = s;
    trig_force = f;
    @(negedge clk);
    trig_valid = 1'b0;
    trig_force = 1'b0;
  endtask

  task automatic expect_idle(input string req);
    chk(trig_ready == 1'b1, req, "trig_ready", 64'(trig_ready), 64'd1);
    chk({rd_req_valid, wr_valid, irq_valid} == 3'b000, req, "no activity",
        64'({rd_req_valid, wr_valid, irq_valid}), 64'd0);
  endtask

  task automatic expect_rd(input logic [ADDR_W-1:0] a, input int hold, input string req);
    for (int i = 0; i < hold; i++) begin
      chk(rd_req_valid && !trig_ready, req, "read held", 64'(rd_req_valid), 64'd1);
      @(negedge clk);
    end
    chk(rd_req_valid == 1'b1, req, "rd_req_valid", 64'(rd_req_valid), 64'd1);
    chk(rd_req_addr == a, req, "rd_req_addr", 64'(rd_req_addr), 64'(a));
    rd_req_ready = 1'b1;
    @(negedge clk);
    rd_req_ready = 1'b0;
  endtask

  task automatic give_rsp(input logic [63:0] d, input bit err, input string req);
    rd_rsp_valid = 1'b1;
    rd_rsp_data  = d;
    rd_rsp_err   = err;
    #1;
    if (err) chk(err_abort == 1'b1, req, "err_abort on read", 64'(err_abort), 64'd1);
    @(negedge clk);
    rd_rsp_valid = 1'b0;
    rd_rsp_err   = 1'b0;
  endtask

  task automatic expect_wr(input logic [ADDR_W-1:0] a, input logic [7:0] d, input bit err,
                           input int hold, input string req);
    for (int i = 0; i < hold; i++) begin
      chk(wr_valid && wr_addr == a, req, "write held", 64'(wr_addr), 64'(a));
      @(negedge clk);
    end
    chk(wr_valid == 1'b1, req, "wr_valid", 64'(wr_valid), 64'd1);
    chk(wr_addr == a, req, "wr_addr", 64'(wr_addr), 64'(a));
    chk(wr_data == d, req, "wr_data", 64'(wr_data), 64'(d));
    chk(irq_valid == 1'b0, req, "no delivery before write", 64'(irq_valid), 64'd0);
    wr_ready = 1'b1;
    @(negedge clk);
    wr_ready     = 1'b0;
    wr_rsp_valid = 1'b1;
    wr_rsp_err   = err;
    #1;
    if (err) chk(err_abort == 1'b1, req, "err_abort on write", 64'(err_abort), 64'd1);
    @(negedge clk);
    wr_rsp_valid = 1'b0;
    wr_rsp_err   = 1'b0;
  endtask

  task automatic expect_irq(input logic [13:0] srv, input logic [IRQ_W-1:0] n,
                            input logic [7:0] pr, input int hold, input string req);
    for (int i = 0; i < hold; i++) begin
      chk(irq_valid && !trig_ready, req, "delivery held", 64'(irq_valid), 64'd1);
      @(negedge clk);
    end
    chk(irq_valid == 1'b1, req, "irq_valid", 64'(irq_valid), 64'd1);
    chk(irq_server == srv, req, "irq_server", 64'(irq_server), 64'(srv));
    chk(irq_num == n, req, "irq_num", 64'(irq_num), 64'(n));
    chk(irq_prio == pr, req, "irq_prio", 64'(irq_prio), 64'(pr));
    irq_ready = 1'b1;
    @(negedge clk);
    irq_ready = 1'b0;
    expect_idle(req);
  endtask

  task automatic t_reset;
    expect_idle("R10");
    chk(err_abort == 1'b0, "R11", "err_abort at reset", 64'(err_abort), 64'd0);
  endtask

  task automatic t_send_small;   // R1 R5 R9
    trig(11'd3, 1'b0);
    expect_rd(BASE + 40'h30, 0, "R1");
    give_rsp(mk_entry(16'h0025, 2'd2, 1'b0, 1'b0, 8'h05), 1'b0, "R9");
    expect_wr(BASE + 40'h34, 8'h05, 1'b0, 0, "R5");
    expect_irq(14'd9, 20'h00103, 8'h05, 0, "R5");
  endtask

  task automatic t_masked_big;   // R1 R4
    cfg_big_entry = 1'b1;
    trig(11'd5, 1'b0);
    expect_rd(BASE + 40'h280, 0, "R1");
    give_rsp(mk_entry(16'h0040, 2'd1, 1'b0, 1'b0, 8'hFF), 1'b0, "R4");
    expect_wr(BASE + 40'h285, 8'h01, 1'b0, 0, "R4");
    expect_idle("R4");
    cfg_big_entry = 1'b0;
  endtask

  task automatic t_pending;      // R6
    trig(11'd7, 1'b0);
    expect_rd(BASE + 40'h70, 0, "R6");
    give_rsp(mk_entry(16'h0010, 2'd0, 1'b1, 1'b0, 8'h03), 1'b0, "R6");
    expect_wr(BASE + 40'h75, 8'h01, 1'b0, 0, "R6");
    expect_idle("R6");
  endtask

  task automatic t_queued;       // R7
    trig(11'd8, 1'b0);
    expect_rd(BASE + 40'h80, 0, "R7");
    give_rsp(mk_entry(16'h0010, 2'd0, 1'b0, 1'b1, 8'h03), 1'b0, "R7");
    expect_idle("R7");
    trig(11'd9, 1'b0);
    expect_rd(BASE + 40'h90, 0, "R7");
    give_rsp(mk_entry(16'h0010, 2'd0, 1'b1, 1'b1, 8'h03), 1'b0, "R7");
    expect_idle("R7");
  endtask

  task automatic t_force;        // R8
    trig(11'd10, 1'b1);
    expect_rd(BASE + 40'hA0, 0, "R8");
    give_rsp(mk_entry(16'h0104, 2'd1, 1'b1, 1'b1, 8'h10), 1'b0, "R8");
    expect_wr(BASE + 40'hA4, 8'h03, 1'b0, 0, "R8");
    expect_irq(14'h041, 20'h0010A, 8'h10, 0, "R8");
    trig(11'd11, 1'b1);
    expect_rd(BASE + 40'hB0, 0, "R8");
    give_rsp(mk_entry(16'h0104, 2'd1, 1'b1, 1'b1, 8'hFF), 1'b0, "R8");
    expect_wr(BASE + 40'hB5, 8'h01, 1'b0, 0, "R8");
    expect_idle("R8");
  endtask

  task automatic t_disabled;     // R2
    cfg_tbl_en = 1'b0;
    trig(11'd3, 1'b0);
    expect_idle("R2");
    @(negedge clk);
    expect_idle("R2");
    cfg_tbl_en = 1'b1;
  endtask

  task automatic t_bound;        // R3
    trig(11'd64, 1'b0);
    expect_idle("R3");
    trig(11'd63, 1'b0);
    expect_rd(BASE + 40'h3F0, 0, "R3");
    give_rsp(mk_entry(16'h0000, 2'd0, 1'b0, 1'b1, 8'h01), 1'b0, "R3");
    expect_idle("R3");
  endtask

  task automatic t_errors;       // R11
    trig(11'd2, 1'b0);
    expect_rd(BASE + 40'h20, 0, "R11");
    give_rsp(mk_entry(16'h0025, 2'd0, 1'b0, 1'b0, 8'h05), 1'b1, "R11");
    expect_idle("R11");
    trig(11'd4, 1'b0);
    expect_rd(BASE + 40'h40, 0, "R11");
    give_rsp(mk_entry(16'h0025, 2'd0, 1'b0, 1'b0, 8'h05), 1'b0, "R11");
    expect_wr(BASE + 40'h44, 8'h01, 1'b1, 0, "R11");
    expect_idle("R11");
  endtask

  task automatic t_backpressure; // R10
    trig(11'd6, 1'b0);
    trig_valid = 1'b1;
    trig_src   = 11'd12;
    expect_rd(BASE + 40'h60, 3, "R10");
    trig_valid = 1'b0;
    give_rsp(mk_entry(16'h0008, 2'd0, 1'b0, 1'b0, 8'h22), 1'b0, "R10");
    expect_wr(BASE + 40'h64, 8'h01, 1'b0, 2, "R10");
    expect_irq(14'd2, 20'h00106, 8'h22, 2, "R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_send_small();
    t_masked_big();
    t_pending();
    t_queued();
    t_force();
    t_disabled();
    t_bound();
    t_errors();
    t_backpressure();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule